// File: doc/BRIEF.md
# Masked Lockstep Processing-Element Array

This block is a row of identical processing elements (PEs) that all obey one instruction per clock. A single control port broadcasts an opcode, an immediate and a local address. Every PE whose activity flag is set carries out the instruction on its own accumulator and its own private memory. Every PE whose flag is clear sits the cycle out. All PEs advance together, so the whole array finishes each instruction in the same cycle.

The activity flags form a mask register with one bit per PE. It can be written directly from outside or set to all ones. It can also be set to a contiguous run of PE indices, or narrowed by a per-PE test of the accumulator sign. This gives conditional execution of the "if negative then negate" kind. Neighbouring PEs exchange accumulators through a cyclic shift that wraps from the last PE back to the first. A readout port returns the accumulator of any one PE chosen by index.

Top module: `simd_pe_array`

## Requirements
- R1: After reset every accumulator and every local memory word is zero, every mask bit is one, and `rdData` is zero.
- R2: A PE whose mask bit is clear when an instruction executes changes neither its accumulator nor its local memory.
- R3: Arithmetic on active PEs wraps in two's complement at DATA_W bits. The opcodes are: 1 loads `instImm`, 2 adds `instImm`, 3 subtracts `instImm`, and 4 negates the accumulator. Each completes in one clock.
- R4: Opcode 7 makes each active PE k take the accumulator of PE (k+1) mod NUM_PE. Opcode 8 takes it from PE (k-1) mod NUM_PE. All values are sampled before any PE updates, and inactive PEs still supply their value.
- R5: Opcode 9 sets mask bit k to its old value AND (accumulator k is negative). An inactive PE therefore stays inactive.
- R6: Opcode 10 sets the mask to ones exactly for indices lo..hi inclusive and zeros elsewhere. lo is `instImm[IDX_W-1:0]` and hi is `instImm[2*IDX_W-1:IDX_W]`. When lo > hi the mask becomes all zeros.
- R7: Opcode 11 sets every mask bit to one.
- R8: When `maskLoad` is high, the mask takes `maskIn` on that edge, whatever instruction is present. `maskOut` always shows the current mask.
- R9: On an active PE, opcode 5 loads the accumulator from local memory and opcode 6 stores the accumulator to local memory. With `instIndexed`=0 the address is `instAddr`. With `instIndexed`=1 it is (`instAddr` + low ADDR_W bits of the PE's own accumulator) mod MEM_DEPTH.
- R10: `rdData` presents, one clock after the request, the accumulator of PE `rdIdx` as it stood at the requesting edge.
- R11: Opcodes 0 and 12 to 15, and any cycle with `instValid` low, change no accumulator, memory word or mask bit. The exception is a mask load under R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Broadcast instruction present |
| instOp | input | 4 | Broadcast opcode |
| instImm | input | DATA_W | Broadcast scalar operand / range fields |
| instAddr | input | ADDR_W | Local memory base address |
| instIndexed | input | 1 | Add the PE's accumulator low bits to the address |
| maskLoad | input | 1 | Write `maskIn` into the mask |
| maskIn | input | NUM_PE | Mask value to load |
| maskOut | output | NUM_PE | Current activity mask |
| rdIdx | input | IDX_W | PE index to read out |
| rdData | output | DATA_W | Registered accumulator of the selected PE |

## Verification
The hardest state to reach is one where every PE holds a different value. The broadcast port can only hand the same immediate to all PEs. The stimulus builds distinct lanes by loading a one-hot mask and then a load-immediate, once per PE. This yields a mix of negative and positive lanes that the shifts, the compare and the indexed addressing can act on. A second hard case is a mask load that coincides with a mask instruction. The bench issues both in one cycle to show which one wins.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_LDI     = 4'd1,
    OP_ADD     = 4'd2,
    OP_SUB     = 4'd3,
    OP_NEG     = 4'd4,
    OP_LDM     = 4'd5,
    OP_STM     = 4'd6,
    OP_PULL_UP = 4'd7,
    OP_PULL_DN = 4'd8,
    OP_CMPNEG  = 4'd9,
    OP_MRANGE  = 4'd10,
    OP_MALL    = 4'd11
  } opcode_e;

  typedef enum logic [2:0] {
    ACC_HOLD, ACC_IMM, ACC_ADD, ACC_SUB, ACC_NEG, ACC_MEM, ACC_UP, ACC_DN
  } accSel_e;

  typedef struct packed {
    accSel_e accSel;
    logic    memWr;
    logic    indexed;
    logic    maskExt;
    logic    maskCmp;
    logic    maskRange;
    logic    maskAll;
  } strobes_t;

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic       instValid,
  input  logic [3:0] instOp,
  input  logic       instIndexed,
  input  logic       maskLoad,
  output strobes_t   strobes
);

  always_comb begin
    strobes         = '0;
    strobes.accSel  = ACC_HOLD;
    strobes.indexed = instIndexed;
    strobes.maskExt = maskLoad;
    if (instValid) begin
      case (opcode_e'(instOp))
        OP_LDI:     strobes.accSel = ACC_IMM;
        OP_ADD:     strobes.accSel = ACC_ADD;
        OP_SUB:     strobes.accSel = ACC_SUB;
        OP_NEG:     strobes.accSel = ACC_NEG;
        OP_LDM:     strobes.accSel = ACC_MEM;
        OP_STM:     strobes.memWr  = 1'b1;
        OP_PULL_UP: strobes.accSel = ACC_UP;
        OP_PULL_DN: strobes.accSel = ACC_DN;
        // an external mask write takes priority over mask instructions
        OP_CMPNEG:  strobes.maskCmp   = !maskLoad;
        OP_MRANGE:  strobes.maskRange = !maskLoad;
        OP_MALL:    strobes.maskAll   = !maskLoad;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
#(
  parameter int NUM_PE    = 8,
  parameter int DATA_W    = 16,
  parameter int MEM_DEPTH = 16,
  localparam int ADDR_W   = $clog2(MEM_DEPTH),
  localparam int IDX_W    = $clog2(NUM_PE)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobes_t                 strobes,
  input  logic [DATA_W-1:0]        imm,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_PE-1:0]        maskIn,
  input  logic [IDX_W-1:0]         rdIdx,
  output logic [NUM_PE-1:0]        maskOut,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_PE*DATA_W-1:0] accFlat
);

  logic [DATA_W-1:0] acc [NUM_PE];
  logic [NUM_PE-1:0] mask, maskNext, rangeHit, negFlag;
  logic [IDX_W-1:0]  rangeLo, rangeHi;

  assign rangeLo = imm[IDX_W-1:0];
  assign rangeHi = imm[2*IDX_W-1:IDX_W];

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    localparam int UP = (k + 1) % NUM_PE;
    localparam int DN = (k + NUM_PE - 1) % NUM_PE;

    logic [DATA_W-1:0] mem [MEM_DEPTH];
    logic [ADDR_W-1:0] peAddr;
    logic [DATA_W-1:0] accNext;

    assign peAddr = strobes.indexed ? addr + acc[k][ADDR_W-1:0] : addr;

    always_comb begin
      case (strobes.accSel)
        ACC_IMM: accNext = imm;
        ACC_ADD: accNext = acc[k] + imm;
        ACC_SUB: accNext = acc[k] - imm;
        ACC_NEG: accNext = '0 - acc[k];
        ACC_MEM: accNext = mem[peAddr];
        ACC_UP:  accNext = acc[UP];
        ACC_DN:  accNext = acc[DN];
        default: accNext = acc[k];
      endcase
    end

    assign rangeHit[k] = (IDX_W'(k) >= rangeLo) && (IDX_W'(k) <= rangeHi);
    assign negFlag[k]  = acc[k][DATA_W-1];
    assign accFlat[k*DATA_W +: DATA_W] = acc[k];

    always_ff @(posedge clk) begin
      if (!rstN) acc[k] <= '0;
      else if (mask[k] && strobes.accSel != ACC_HOLD) acc[k] <= accNext;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
      end else if (mask[k] && strobes.memWr) begin
        mem[peAddr] <= acc[k];
      end
    end
  end

  always_comb begin
    maskNext = mask;
    if (strobes.maskExt)        maskNext = maskIn;
    else if (strobes.maskAll)   maskNext = '1;
    else if (strobes.maskRange) maskNext = rangeHit;
    else if (strobes.maskCmp)   maskNext = mask & negFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask   <= '1;
      rdData <= '0;
    end else begin
      mask   <= maskNext;
      rdData <= acc[rdIdx];
    end
  end

  assign maskOut = mask;

endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_pkg::*;
#(
  parameter int NUM_PE    = 8,
  parameter int DATA_W    = 16,
  parameter int MEM_DEPTH = 16,
  localparam int ADDR_W   = $clog2(MEM_DEPTH),
  localparam int IDX_W    = $clog2(NUM_PE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        instOp,
  input  logic [DATA_W-1:0] instImm,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic              instIndexed,
  input  logic              maskLoad,
  input  logic [NUM_PE-1:0] maskIn,
  output logic [NUM_PE-1:0] maskOut,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);

  strobes_t                 strobes;
  logic [NUM_PE*DATA_W-1:0] accFlat;

  simd_ctrl u_ctrl (
    .instValid  (instValid),
    .instOp     (instOp),
    .instIndexed(instIndexed),
    .maskLoad   (maskLoad),
    .strobes    (strobes)
  );

  simd_datapath #(
    .NUM_PE   (NUM_PE),
    .DATA_W   (DATA_W),
    .MEM_DEPTH(MEM_DEPTH)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .imm    (instImm),
    .addr   (instAddr),
    .maskIn (maskIn),
    .rdIdx  (rdIdx),
    .maskOut(maskOut),
    .rdData (rdData),
    .accFlat(accFlat)
  );

endmodule

// File: rtl/simd_pe_array_chk.sv
module simd_pe_array_chk #(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     instValid,
  input logic [3:0]               instOp,
  input logic [DATA_W-1:0]        instImm,
  input logic                     maskLoad,
  input logic [NUM_PE-1:0]        maskIn,
  input logic [NUM_PE-1:0]        maskOut,
  input logic [IDX_W-1:0]         rdIdx,
  input logic [DATA_W-1:0]        rdData,
  input logic [NUM_PE*DATA_W-1:0] accFlat
);

  for (genvar k = 0; k < NUM_PE; k++) begin : g_lane
    assert_inactive_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      !maskOut[k] |=> $stable(accFlat[k*DATA_W +: DATA_W]));

    assert_load_imm_R3: assert property (@(posedge clk) disable iff (!rstN)
      (instValid && instOp == 4'd1 && maskOut[k])
        |=> accFlat[k*DATA_W +: DATA_W] == $past(instImm));
  end

  assert_mask_all_R7: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instOp == 4'd11 && !maskLoad) |=> (&maskOut));

  assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    maskLoad |=> maskOut == $past(maskIn));

  assert_readout_R10: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> rdData == $past(accFlat[rdIdx*DATA_W +: DATA_W]));

endmodule

bind simd_pe_array simd_pe_array_chk #(
  .NUM_PE(NUM_PE),
  .DATA_W(DATA_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .instValid(instValid),
  .instOp   (instOp),
  .instImm  (instImm),
  .maskLoad (maskLoad),
  .maskIn   (maskIn),
  .maskOut  (maskOut),
  .rdIdx    (rdIdx),
  .rdData   (rdData),
  .accFlat  (accFlat)
);

// File: tb/simd_pe_array_bench.sv
module simd_pe_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPE = 8;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int IW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic instValid = 1'b0, instIndexed = 1'b0, maskLoad = 1'b0;
  logic [3:0] instOp = '0;
  logic [DW-1:0] instImm = '0;
  logic [AW-1:0] instAddr = '0;
  logic [NPE-1:0] maskIn = '0, maskOut;
  logic [IW-1:0] rdIdx = '0;
  logic [DW-1:0] rdData;

  simd_pe_array u_simd_pe_array (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .instImm(instImm), .instAddr(instAddr), .instIndexed(instIndexed),
    .maskLoad(maskLoad), .maskIn(maskIn), .maskOut(maskOut),
    .rdIdx(rdIdx), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cycleCount = 0;
  always @(posedge clk) cycleCount++;

  // reference model built from the requirements
  logic [DW-1:0]  mAcc [NPE];
  logic [NPE-1:0] mMask;
  logic [DW-1:0]  mMem [NPE][DEPTH];

  logic [DW-1:0] expQ[$];
  int            dueQ[$];
  string         tagQ[$];
  int nRun = 0, nFail = 0;

  task automatic issue(input logic [3:0] op, input logic [DW-1:0] imm,
                       input logic [AW-1:0] a = '0, input logic idxd = 1'b0,
                       input logic ml = 1'b0, input logic [NPE-1:0] mi = '0,
                       input logic v = 1'b1);
    logic [DW-1:0]  old [NPE];
    logic [NPE-1:0] nm;
    logic [AW-1:0]  ad;
    logic [IW-1:0]  lo, hi;
    @(negedge clk);
    instValid = v; instOp = op; instImm = imm; instAddr = a;
    instIndexed = idxd; maskLoad = ml; maskIn = mi;
    for (int k = 0; k < NPE; k++) old[k] = mAcc[k];
    if (v) begin
      for (int k = 0; k < NPE; k++) begin
        if (mMask[k]) begin
          ad = idxd ? AW'(a + old[k][AW-1:0]) : a;
          case (op)
            4'd1: mAcc[k] = imm;
            4'd2: mAcc[k] = old[k] + imm;
            4'd3: mAcc[k] = old[k] - imm;
            4'd4: mAcc[k] = -old[k];
            4'd5: mAcc[k] = mMem[k][ad];
            4'd6: mMem[k][ad] = old[k];
            4'd7: mAcc[k] = old[(k + 1) % NPE];
            4'd8: mAcc[k] = old[(k + NPE - 1) % NPE];
            default: ;
          endcase
        end
      end
    end
    nm = mMask;
    lo = imm[IW-1:0];
    hi = imm[2*IW-1:IW];
    if (ml) nm = mi;
    else if (v) begin
      case (op)
        4'd9:  for (int k = 0; k < NPE; k++) nm[k] = mMask[k] & old[k][DW-1];
        4'd10: for (int k = 0; k < NPE; k++) nm[k] = (k >= int'(lo)) && (k <= int'(hi));
        4'd11: nm = '1;
        default: ;
      endcase
    end
    mMask = nm;
  endtask

  task automatic readAcc(input int k, input string tag);
    @(negedge clk);
    instValid = 1'b0; maskLoad = 1'b0; rdIdx = IW'(k);
    expQ.push_back(mAcc[k]);
    dueQ.push_back(cycleCount + 1);
    tagQ.push_back($sformatf("%s pe%0d", tag, k));
  endtask

  task automatic readAll(input string tag);
    for (int k = 0; k < NPE; k++) readAcc(k, tag);
  endtask

  task automatic checkMask(input string tag);
    @(negedge clk);
    instValid = 1'b0; maskLoad = 1'b0;
    #1;
    nRun++;
    if (maskOut !== mMask) begin
      nFail++;
      $display("FAIL %s: maskOut=%b expected %b", tag, maskOut, mMask);
    end
  endtask

  task automatic loadLanes(input int base, input int step);
    for (int k = 0; k < NPE; k++) begin
      issue(4'd0, '0, '0, 1'b0, 1'b1, NPE'(1 << k));
      issue(4'd1, DW'(base + step * k));
    end
    issue(4'd11, '0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (dueQ.size() > 0 && dueQ[0] <= cycleCount) begin
        logic [DW-1:0] e;
        string t;
        e = expQ.pop_front();
        void'(dueQ.pop_front());
        t = tagQ.pop_front();
        nRun++;
        if (rdData !== e) begin
          nFail++;
          $display("FAIL %s: rdData=%h expected %h", t, rdData, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NPE; k++) begin
      mAcc[k] = '0;
      for (int i = 0; i < DEPTH; i++) mMem[k][i] = '0;
    end
    mMask = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkMask("R1 reset mask");
    readAll("R1 reset acc");
    issue(4'd5, '0, 4'd3);
    readAcc(0, "R1 reset memory");
    readAcc(7, "R1 reset memory");

    // R3 wrap-around arithmetic
    issue(4'd1, 16'h7FFF);
    issue(4'd2, 16'h0001);
    readAcc(2, "R3 add wraps");
    issue(4'd4, '0);
    readAcc(5, "R3 negate of minimum");
    issue(4'd3, 16'h0001);
    readAcc(1, "R3 subtract wraps");
    loadLanes(-20, 7);
    readAll("R3 per-lane load");

    // R2 inactive lanes keep accumulator and memory
    issue(4'd0, '0, '0, 1'b0, 1'b1, 8'b0101_0101);
    issue(4'd2, 16'd100);
    issue(4'd6, '0, 4'd5);
    readAll("R2 inactive hold");

    // R7 all-on, R4 neighbour pulls
    issue(4'd11, '0);
    checkMask("R7 set all");
    issue(4'd7, '0);
    readAll("R4 pull from k+1");
    issue(4'd0, '0, '0, 1'b0, 1'b1, 8'b1111_0000);
    issue(4'd8, '0);
    readAll("R4 masked pull from k-1");

    // R5 compare and narrowing
    issue(4'd11, '0);
    issue(4'd9, '0);
    checkMask("R5 compare negative");
    issue(4'd4, '0);
    readAll("R5 negate negatives");
    issue(4'd9, '0);
    checkMask("R5 narrowing empty");

    // R6 range
    issue(4'd10, DW'((5 << 3) | 2));
    checkMask("R6 range 2..5");
    issue(4'd10, DW'((2 << 3) | 5));
    checkMask("R6 lo above hi");
    issue(4'd10, DW'((7 << 3) | 7));
    checkMask("R6 single top lane");

    // R8 external load wins
    issue(4'd11, '0, '0, 1'b0, 1'b1, 8'h0F);
    checkMask("R8 load beats set-all");
    issue(4'd9, '0, '0, 1'b0, 1'b1, 8'hA5);
    checkMask("R8 load beats compare");

    // R9 local memory, direct and indexed
    issue(4'd11, '0);
    loadLanes(16, 1);
    issue(4'd6, '0, 4'd4, 1'b1);
    issue(4'd5, '0, 4'd7);
    readAll("R9 direct load after indexed store");
    loadLanes(16, 1);
    issue(4'd5, '0, 4'd4, 1'b1);
    readAll("R9 indexed load");
    issue(4'd5, '0, 4'd5);
    readAll("R2 masked store untouched");

    // R11 no-effect cycles
    issue(4'd15, 16'h1234);
    issue(4'd2, 16'h0055, '0, 1'b0, 1'b0, '0, 1'b0);
    issue(4'd11, '0, '0, 1'b0, 1'b0, '0, 1'b0);
    issue(4'd10, 16'h0009, '0, 1'b0, 1'b0, '0, 1'b0);
    readAll("R11 no effect acc");
    checkMask("R11 no effect mask");

    // R10 back-to-back readout latency
    readAcc(6, "R10 latency");
    readAcc(3, "R10 latency");

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule